// File: doc/BRIEF.md
# Hypercube Dimension-Order Route Selector

This block makes the routing decision for one node of a binary n-cube network of 2^n nodes, each named by an n-bit address. A packet header arrives carrying the destination address, and the node's own address arrives beside it. The block XORs the two addresses. It picks the output link of the lowest dimension in which they differ. If they match, it picks the local delivery port instead. It also reports how many hops the packet still has to make. Because the dimension order is fixed, every packet between a given pair of nodes follows one path.

Headers enter through a valid/ready handshake and are registered on acceptance. The decision appears on the following cycle, marked by an output valid. The decision is a one-hot port select of n+1 bits and a hop count. The single output register can be drained and refilled in the same cycle, so the block takes one header per cycle while the consumer keeps its ready high. When the consumer stalls, the decision stays frozen and new headers are held off.

Top module: `hc_route_unit`

## Requirements
- R1: After reset is released, out_valid is 0 and in_ready is 1.
- R2: A header is taken on a rising edge where in_valid and in_ready are both 1. Its decision is shown with out_valid = 1 from that edge until the edge on which out_ready is 1.
- R3: When the two addresses differ, out_port_sel has exactly one bit set. That bit is bit i, where i is the lowest dimension whose bit differs between the local address and the destination address.
- R4: When the local address equals the destination address, out_port_sel has only bit n set, which is the local delivery port, and out_hops is 0.
- R5: out_hops equals the number of bit positions in which the two addresses differ. Its width is clog2(n+1), so the maximum value n is reached when one address is the complement of the other.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0. In that state out_port_sel and out_hops stay unchanged, and any header offered is not taken.
- R7: If each hop's next local address is the current one with the selected dimension bit flipped, a packet from 0000 to 0111 (n = 4) selects dimensions 0, 1 and 2 in turn and then the local port.
- R8: When out_ready is 1, in_ready is 1. A header offered on consecutive cycles is accepted on each cycle, and a new decision appears each cycle.
- R9: Asserting rst_n low clears out_valid even while a decision is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Header can be taken this cycle |
| in_node_addr | input | N_DIMS | Address of this node |
| in_dest_addr | input | N_DIMS | Destination address from the header |
| out_valid | output | 1 | Decision available |
| out_ready | input | 1 | Consumer takes the decision |
| out_port_sel | output | N_DIMS+1 | One-hot port: bit i = dimension i link, bit N_DIMS = local delivery |
| out_hops | output | clog2(N_DIMS+1) | Hops remaining to destination |

## Verification
Two events can fall on the same edge: a decision is drained by out_ready while the next header is accepted into the same register. The bench sets this up by stalling a decision and offering a second header, which must be refused. It then raises out_ready for one edge and checks that the second header's port and hop count replace the first without a gap. Back-to-back streaming with out_ready held high exercises the same overlap on every cycle, and each result is compared against a hand-computed table entry.

// File: rtl/hc_route_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helpers for the hypercube route selector.
// Assumes dimension counts between 1 and 16.
package hc_route_pkg;
    localparam int unsigned HC_DEF_DIMS = 4;

    // Width needed to hold a hop count of 0..dims.
    function automatic int unsigned hop_width(input int unsigned dims);
        return $clog2(dims + 1);
    endfunction
endpackage

// File: rtl/hc_addr_diff.sv
`timescale 1ns/1ps
// Module: forms the per-dimension difference vector of two node addresses
// and counts its set bits (Hamming distance). Purely combinational.
module hc_addr_diff #(
    parameter int unsigned N_DIMS = 4,
    parameter int unsigned HOP_W  = 3
) (
    input  logic [N_DIMS-1:0] node_addr,
    input  logic [N_DIMS-1:0] dest_addr,
    output logic [N_DIMS-1:0] diff,
    output logic [HOP_W-1:0]  hops
);
    assign diff = node_addr ^ dest_addr;

    // Population count of the difference vector.
    always_comb begin
        hops = '0;
        for (int i = 0; i < int'(N_DIMS); i++) begin
            hops = hops + HOP_W'(diff[i]);
        end
    end
endmodule

// File: rtl/hc_dim_pick.sv
`timescale 1ns/1ps
// Module: lowest-first priority pick over the difference vector. Produces a
// one-hot select of N_DIMS+1 bits; the top bit means no difference (local).
module hc_dim_pick #(
    parameter int unsigned N_DIMS = 4
) (
    input  logic [N_DIMS-1:0] diff,
    output logic [N_DIMS:0]   port_sel
);
    logic [N_DIMS:0] clear_below;

    assign clear_below[0] = 1'b1;

    for (genvar g = 0; g < N_DIMS; g++) begin : g_dim
        // Dimension g wins when it differs and every lower one matches.
        assign port_sel[g]      = diff[g] & clear_below[g];
        assign clear_below[g+1] = clear_below[g] & ~diff[g];
    end

    assign port_sel[N_DIMS] = clear_below[N_DIMS];
endmodule

// File: rtl/hc_out_reg.sv
`timescale 1ns/1ps
// Module: single output register with valid/ready on both sides. Refills
// in the same cycle it drains; holds contents while the consumer stalls.
module hc_out_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    assign up_ready = ~full_q | dn_ready;
    assign dn_valid = full_q;
    assign dn_data  = data_q;

    // Occupancy: refilled or emptied whenever the slot is free or drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (up_ready) begin
            full_q <= up_valid;
        end
    end

    // Payload: captured only on an accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (up_valid && up_ready) begin
            data_q <= up_data;
        end
    end
endmodule

// File: rtl/hc_route_unit.sv
`timescale 1ns/1ps
// Module: dimension-order route selector for one hypercube node. Accepts a
// header (node and destination address), registers the chosen port and
// remaining hop count, and presents them one cycle later.
// Assumes addresses are stable while in_valid is high.
module hc_route_unit
    import hc_route_pkg::*;
#(
    parameter int unsigned N_DIMS = HC_DEF_DIMS,
    parameter int unsigned HOP_W  = hop_width(N_DIMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [N_DIMS-1:0] in_node_addr,
    input  logic [N_DIMS-1:0] in_dest_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [N_DIMS:0]   out_port_sel,
    output logic [HOP_W-1:0]  out_hops
);
    localparam int unsigned SEL_W  = N_DIMS + 1;
    localparam int unsigned DATA_W = SEL_W + HOP_W;

    logic [N_DIMS-1:0] diff;
    logic [HOP_W-1:0]  hops_c;
    logic [SEL_W-1:0]  sel_c;
    logic [DATA_W-1:0] dn_data;

    hc_addr_diff #(.N_DIMS(N_DIMS), .HOP_W(HOP_W)) u_diff (
        .node_addr (in_node_addr),
        .dest_addr (in_dest_addr),
        .diff      (diff),
        .hops      (hops_c)
    );

    hc_dim_pick #(.N_DIMS(N_DIMS)) u_pick (
        .diff     (diff),
        .port_sel (sel_c)
    );

    hc_out_reg #(.DATA_W(DATA_W)) u_oreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  ({sel_c, hops_c}),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (dn_data)
    );

    assign out_port_sel = dn_data[DATA_W-1:HOP_W];
    assign out_hops     = dn_data[HOP_W-1:0];
endmodule

// File: rtl/hc_route_unit_chk.sv
`timescale 1ns/1ps
// Module: property checker for hc_route_unit, attached by bind below.
module hc_route_unit_chk #(
    parameter int unsigned N_DIMS = 4,
    parameter int unsigned HOP_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [N_DIMS:0]   out_port_sel,
    input logic [HOP_W-1:0]  out_hops
);
    // R3: a valid decision names exactly one port.
    a_r3_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_port_sel) == 1);

    // R4: local delivery goes with zero hops.
    a_r4_local_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port_sel[N_DIMS]) |-> out_hops == '0);

    // R5: a link port implies hops in 1..N_DIMS.
    a_r5_hops_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_port_sel[N_DIMS]) |-> (out_hops != '0 && out_hops <= HOP_W'(N_DIMS)));

    // R6: a stalled decision holds still.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port_sel) && $stable(out_hops)));

    // R6: no header is taken while stalled.
    a_r6_block: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R2: an accepted header yields a decision next cycle.
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
endmodule

bind hc_route_unit hc_route_unit_chk #(.N_DIMS(N_DIMS), .HOP_W(HOP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_port_sel (out_port_sel),
    .out_hops     (out_hops)
);

// File: tb/hc_route_unit_bench.sv
`timescale 1ns/1ps
module hc_route_unit_bench;
    localparam int N = 4;
    localparam int HW = 3;
    localparam int NV = 10;
    // {node[4], dest[4], sel[5], hops[3]}
    localparam logic [15:0] VEC [NV] = '{
        {4'b0000, 4'b1111, 5'b00001, 3'd4},
        {4'b0101, 4'b0101, 5'b10000, 3'd0},
        {4'b0001, 4'b0011, 5'b00010, 3'd1},
        {4'b1000, 4'b0000, 5'b01000, 3'd1},
        {4'b0110, 4'b1010, 5'b00100, 3'd2},
        {4'b1111, 4'b0000, 5'b00001, 3'd4},
        {4'b1010, 4'b0011, 5'b00001, 3'd2},
        {4'b0011, 4'b1011, 5'b01000, 3'd1},
        {4'b1110, 4'b0001, 5'b00001, 3'd4},
        {4'b0000, 4'b0000, 5'b10000, 3'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [N-1:0] in_node_addr = '0;
    logic [N-1:0] in_dest_addr = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [N:0] out_port_sel;
    logic [HW-1:0] out_hops;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hc_route_unit u_hc_route_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_node_addr(in_node_addr), .in_dest_addr(in_dest_addr),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_port_sel(out_port_sel), .out_hops(out_hops)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] cur;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 in_ready", 32'(in_ready), 1);

        // Table walk: one header at a time, consumer ready (R2 R3 R4 R5)
        out_ready = 1'b1;
        for (int k = 0; k < NV; k++) begin
            in_node_addr = VEC[k][15:12];
            in_dest_addr = VEC[k][11:8];
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R2 out_valid", 32'(out_valid), 1);
            chk("R3 port", 32'(out_port_sel), 32'(VEC[k][7:3]));
            chk("R5 hops", 32'(out_hops), 32'(VEC[k][2:0]));
            @(negedge clk);
            chk("R2 drained", 32'(out_valid), 0);
        end

        // R7: follow path 0000 -> 0111
        cur = 4'b0000;
        for (int h = 0; h < 4; h++) begin
            in_node_addr = cur;
            in_dest_addr = 4'b0111;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R7 path port", 32'(out_port_sel), (h < 3) ? (32'd1 << h) : 32'h10);
            chk("R7 path hops", 32'(out_hops), 32'(3 - h));
            for (int b = 0; b < N; b++) if (out_port_sel[b]) cur[b] = ~cur[b];
            @(negedge clk);
        end

        // R8: back-to-back stream
        in_valid = 1'b1;
        for (int k = 2; k < 6; k++) begin
            in_node_addr = VEC[k][15:12];
            in_dest_addr = VEC[k][11:8];
            chk("R8 in_ready", 32'(in_ready), 1);
            @(negedge clk);
            chk("R8 stream port", 32'(out_port_sel), 32'(VEC[k][7:3]));
            chk("R8 stream hops", 32'(out_hops), 32'(VEC[k][2:0]));
        end
        in_valid = 1'b0;
        @(negedge clk);

        // R6: stall, offer a second header, then drain and refill together
        out_ready = 1'b0;
        in_node_addr = 4'b0110; in_dest_addr = 4'b1010; in_valid = 1'b1;
        @(negedge clk);
        in_node_addr = 4'b0101; in_dest_addr = 4'b0101;
        chk("R6 in_ready low", 32'(in_ready), 0);
        repeat (2) @(negedge clk);
        chk("R6 held port", 32'(out_port_sel), 32'h04);
        chk("R6 held hops", 32'(out_hops), 2);
        chk("R6 held valid", 32'(out_valid), 1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 refill port", 32'(out_port_sel), 32'h10);
        chk("R4 refill hops", 32'(out_hops), 0);
        chk("R6 refill valid", 32'(out_valid), 1);
        @(negedge clk);

        // R9: reset while a decision is pending
        out_ready = 1'b0;
        in_node_addr = 4'b0000; in_dest_addr = 4'b1111; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 cleared", 32'(out_valid), 0);
        chk("R1 ready after reset", 32'(in_ready), 1);
        @(negedge clk);
        finish_run();
    end
endmodule